// File: doc/BRIEF.md
# JTAG test access port controller

This block is a boundary-scan test port for a small chip. Five pins reach it: a test clock, a mode-select line, an active-low asynchronous reset, a serial input and a serial output. A sixteen-state controller steps on each rising test-clock edge according to the mode-select line. The controller drives a 4-bit instruction register and three data registers: a single bypass bit, a 32-bit identification word, and a generic boundary chain of input and output cells.

Every output cell has an update latch. A mode signal chooses whether the chip's output pins follow the functional core or the update latches. During normal operation the controller rests in its reset state with the identification instruction loaded, so the core owns the pins. Board test software then scans in instructions to sample the pins, drive interconnect patterns, clamp the outputs or read the chip's identity.

Top module: `tap_port_top`

## Requirements
- R1: While `trstN` is low, the controller is in Test-Logic-Reset and `tdoEn` is 0, with no clock needed. The instruction is IDCODE, so `scanMode` is 0 and `pinOut` equals `coreOut`. All update latches clear to 0.
- R2: From any state, five rising `tck` edges with `tms` high reach Test-Logic-Reset. The state machine follows the standard sixteen-state 1149.1 transition graph.
- R3: In Capture-IR the 4-bit instruction shift register loads 4'b0001. In Shift-IR it shifts toward bit 0, taking `tdi` into bit 3 and presenting bit 0 on `tdo`. Update-IR loads it into the instruction.
- R4: Under IDCODE (4'b0011), Capture-DR loads `{ID_HIGH, 1'b1}`, and shifting presents it least significant bit first.
- R5: Under BYPASS (4'b1111), and under any code other than 4'b0000, 4'b0001, 4'b0010 and 4'b0011, the data path is one bit long. That bit captures 0, so `tdo` repeats `tdi` one shift later.
- R6: Under SAMPLE (4'b0001), Capture-DR loads `pinIn` into chain bits [NUM_IN-1:0] and `coreOut` into the bits above them. The bits are shifted out least significant first. `scanMode` stays 0 and `pinOut` follows `coreOut`.
- R7: Update-DR under SAMPLE or EXTEST (4'b0000) copies the upper NUM_OUT chain bits into the update latches. Under EXTEST, `scanMode` is 1 and `pinOut` shows the latches whatever `coreOut` does.
- R8: Under CLAMP (4'b0010), `scanMode` is 1 and `pinOut` holds the latches. The data path is the one-bit bypass, and Update-DR leaves the latches unchanged.
- R9: `tdo` and `tdoEn` change only on the falling edge of `tck`. `tdoEn` is 1 exactly while the controller is in Shift-DR or Shift-IR.
- R10: Any rising edge taken in Test-Logic-Reset loads IDCODE into the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge |
| trstN | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdoEn | output | 1 | Output enable for `tdo`; 0 means high impedance |
| pinIn | input | NUM_IN | Values seen at the chip's input pins |
| coreOut | input | NUM_OUT | Values the functional core wants on its output pins |
| pinOut | output | NUM_OUT | Values driven onto the output pins |
| scanMode | output | 1 | 1 when the update latches own the output pins |

## Verification
Two pairs of events can land on the same clock edge. In the first, the final bit of a scan shifts on the same rising edge that leaves Shift-DR or Shift-IR, because every scan ends with `tms` high. The bench does this on every scan and compares the collected bits with values computed from the requirements. In the second, the asynchronous reset falls between edges while `tdoEn` is high in Shift-DR under EXTEST. The bench then checks right away that the output enable drops and the pins return to the core, before any clock arrives. A queue-based behavioural model is also compared on every falling edge.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_WIDTH = 4;

  localparam logic [IR_WIDTH-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_WIDTH-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_WIDTH-1:0] OP_CLAMP   = 4'b0010;
  localparam logic [IR_WIDTH-1:0] OP_IDCODE  = 4'b0011;
  localparam logic [IR_WIDTH-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_WIDTH-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    StReset, StIdle,
    StSelDr, StCapDr, StShDr, StEx1Dr, StPauseDr, StEx2Dr, StUpDr,
    StSelIr, StCapIr, StShIr, StEx1Ir, StPauseIr, StEx2Ir, StUpIr
  } tapState_e;

  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic resetIr;
  } tapStrobe_t;
endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapStrobe_t strobe
);
  tapState_e state, nextState;

  always_comb begin
    case (state)
      StReset:   nextState = tms ? StReset : StIdle;
      StIdle:    nextState = tms ? StSelDr : StIdle;
      StSelDr:   nextState = tms ? StSelIr : StCapDr;
      StCapDr:   nextState = tms ? StEx1Dr : StShDr;
      StShDr:    nextState = tms ? StEx1Dr : StShDr;
      StEx1Dr:   nextState = tms ? StUpDr : StPauseDr;
      StPauseDr: nextState = tms ? StEx2Dr : StPauseDr;
      StEx2Dr:   nextState = tms ? StUpDr : StShDr;
      StUpDr:    nextState = tms ? StSelDr : StIdle;
      StSelIr:   nextState = tms ? StReset : StCapIr;
      StCapIr:   nextState = tms ? StEx1Ir : StShIr;
      StShIr:    nextState = tms ? StEx1Ir : StShIr;
      StEx1Ir:   nextState = tms ? StUpIr : StPauseIr;
      StPauseIr: nextState = tms ? StEx2Ir : StPauseIr;
      StEx2Ir:   nextState = tms ? StUpIr : StShIr;
      StUpIr:    nextState = tms ? StSelDr : StIdle;
      default:   nextState = StReset;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= StReset;
    else        state <= nextState;
  end

  always_comb begin
    strobe.captureDr = (state == StCapDr);
    strobe.shiftDr   = (state == StShDr);
    strobe.updateDr  = (state == StUpDr);
    strobe.captureIr = (state == StCapIr);
    strobe.shiftIr   = (state == StShIr);
    strobe.updateIr  = (state == StUpIr);
    strobe.resetIr   = (state == StReset);
  end

  // Independent count of consecutive mode-select-high edges
  logic [2:0] tmsHighCnt;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              tmsHighCnt <= '0;
    else if (!tms)           tmsHighCnt <= '0;
    else if (tmsHighCnt != 3'd5) tmsHighCnt <= 3'(tmsHighCnt + 3'd1);
  end

  // R2
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tmsHighCnt == 3'd5) |-> (state == StReset));
endmodule

// File: rtl/tap_dpath.sv
module tap_dpath
  import tap_pkg::*;
#(
  parameter int          NUM_IN  = 4,
  parameter int          NUM_OUT = 4,
  parameter logic [30:0] ID_HIGH = 31'h15A3C0E7
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  tapStrobe_t         strobe,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  output logic               tdo,
  output logic               tdoEn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic               scanMode
);
  localparam int CHAIN    = NUM_IN + NUM_OUT;
  localparam int ID_WIDTH = 32;

  logic [IR_WIDTH-1:0] irShift, irReg;
  logic                bypassBit;
  logic [ID_WIDTH-1:0] idShift;
  logic [CHAIN-1:0]    bsrShift;
  logic [NUM_OUT-1:0]  updLatch;
  logic selId, selBsr, extMode, serialOut;

  // Instruction register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      irReg   <= OP_IDCODE;
    end else begin
      if (strobe.captureIr)    irShift <= IR_CAPTURE;
      else if (strobe.shiftIr) irShift <= {tdi, irShift[IR_WIDTH-1:1]};
      if (strobe.resetIr)       irReg <= OP_IDCODE;
      else if (strobe.updateIr) irReg <= irShift;
    end
  end

  always_comb begin
    selId   = (irReg == OP_IDCODE);
    selBsr  = (irReg == OP_EXTEST) || (irReg == OP_SAMPLE);
    extMode = (irReg == OP_EXTEST) || (irReg == OP_CLAMP);
  end

  // Data registers
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
      idShift   <= '0;
      bsrShift  <= '0;
      updLatch  <= '0;
    end else begin
      if (strobe.captureDr) begin
        bypassBit <= 1'b0;
        if (selId)  idShift  <= {ID_HIGH, 1'b1};
        if (selBsr) bsrShift <= {coreOut, pinIn};
      end else if (strobe.shiftDr) begin
        if (selId)                bypassBit <= bypassBit;
        else if (!selBsr)         bypassBit <= tdi;
        if (selId)  idShift  <= {tdi, idShift[ID_WIDTH-1:1]};
        if (selBsr) bsrShift <= {tdi, bsrShift[CHAIN-1:1]};
      end else if (strobe.updateDr && selBsr) begin
        updLatch <= bsrShift[CHAIN-1:NUM_IN];
      end
    end
  end

  // Output cells: one multiplexer per pin
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_outCell
    assign pinOut[i] = extMode ? updLatch[i] : coreOut[i];
  end
  assign scanMode = extMode;

  always_comb begin
    if (strobe.shiftIr)  serialOut = irShift[0];
    else if (selId)      serialOut = idShift[0];
    else if (selBsr)     serialOut = bsrShift[0];
    else                 serialOut = bypassBit;
  end

  // Falling-edge output stage
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialOut;
      tdoEn <= strobe.shiftDr | strobe.shiftIr;
    end
  end

  // R9
  tdo_enable_state_chk: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (strobe.shiftDr || strobe.shiftIr));

  // R10
  reset_loads_id_chk: assert property (@(posedge tck) disable iff (!trstN)
    strobe.resetIr |=> (irReg == OP_IDCODE));

  // R5
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.shiftDr && !selId && !selBsr) |=> (bypassBit == $past(tdi)));

  // R8
  clamp_latch_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    (irReg == OP_CLAMP) |=> $stable(updLatch));
endmodule

// File: rtl/tap_port_top.sv
module tap_port_top
  import tap_pkg::*;
#(
  parameter int          NUM_IN  = 4,
  parameter int          NUM_OUT = 4,
  parameter logic [30:0] ID_HIGH = 31'h15A3C0E7
) (
  input  logic               tck,
  input  logic               tms,
  input  logic               trstN,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdoEn,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  output logic [NUM_OUT-1:0] pinOut,
  output logic               scanMode
);
  tapStrobe_t strobe;

  tap_ctrl u_ctrl (
    .tck    (tck),
    .trstN  (trstN),
    .tms    (tms),
    .strobe (strobe)
  );

  tap_dpath #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .ID_HIGH (ID_HIGH)
  ) u_dpath (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .strobe   (strobe),
    .pinIn    (pinIn),
    .coreOut  (coreOut),
    .tdo      (tdo),
    .tdoEn    (tdoEn),
    .pinOut   (pinOut),
    .scanMode (scanMode)
  );
endmodule

// File: tb/tap_port_top_test.sv
`timescale 1ns/100ps
module tap_port_top_test;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam logic [30:0] IDH = 31'h15A3C0E7;
  localparam logic [31:0] IDFULL = {IDH, 1'b1};

  localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4,
                 S_EX1DR = 5, S_PDR = 6, S_EX2DR = 7, S_UPDR = 8, S_SELIR = 9,
                 S_CAPIR = 10, S_SHIR = 11, S_EX1IR = 12, S_PIR = 13,
                 S_EX2IR = 14, S_UPIR = 15;

  logic tck = 1'b0, tms = 1'b1, trstN = 1'b0, tdi = 1'b0;
  logic tdo, tdoEn, scanMode;
  logic [NI-1:0] pinIn = '0;
  logic [NO-1:0] coreOut = '0;
  logic [NO-1:0] pinOut;

  int nChecks = 0, nFail = 0;

  always #2 tck = ~tck;

  tap_port_top #(.NUM_IN(NI), .NUM_OUT(NO), .ID_HIGH(IDH)) uut (
    .tck(tck), .tms(tms), .trstN(trstN), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .pinIn(pinIn), .coreOut(coreOut), .pinOut(pinOut), .scanMode(scanMode)
  );

  // Behavioural reference model
  int mst;
  bit [3:0] mInstr;
  bit [NO-1:0] mLatch;
  bit irQ[$];
  bit drQ[$];

  function automatic int nextSt(int s, bit t);
    case (s)
      S_TLR:   return t ? S_TLR : S_RTI;
      S_RTI:   return t ? S_SELDR : S_RTI;
      S_SELDR: return t ? S_SELIR : S_CAPDR;
      S_CAPDR: return t ? S_EX1DR : S_SHDR;
      S_SHDR:  return t ? S_EX1DR : S_SHDR;
      S_EX1DR: return t ? S_UPDR : S_PDR;
      S_PDR:   return t ? S_EX2DR : S_PDR;
      S_EX2DR: return t ? S_UPDR : S_SHDR;
      S_UPDR:  return t ? S_SELDR : S_RTI;
      S_SELIR: return t ? S_TLR : S_CAPIR;
      S_CAPIR: return t ? S_EX1IR : S_SHIR;
      S_SHIR:  return t ? S_EX1IR : S_SHIR;
      S_EX1IR: return t ? S_UPIR : S_PIR;
      S_PIR:   return t ? S_EX2IR : S_PIR;
      S_EX2IR: return t ? S_UPIR : S_SHIR;
      default: return t ? S_SELDR : S_RTI;
    endcase
  endfunction

  function automatic bit mIsBsr();  return (mInstr == 4'b0000) || (mInstr == 4'b0001); endfunction
  function automatic bit mIsExt();  return (mInstr == 4'b0000) || (mInstr == 4'b0010); endfunction

  task automatic modelReset();
    mst = S_TLR; mInstr = 4'b0011; mLatch = '0;
    irQ.delete(); drQ.delete();
  endtask

  task automatic modelEdge(bit t, bit d);
    case (mst)
      S_TLR: mInstr = 4'b0011;
      S_CAPIR: begin
        irQ.delete();
        irQ.push_back(1'b1); irQ.push_back(1'b0); irQ.push_back(1'b0); irQ.push_back(1'b0);
      end
      S_SHIR: begin void'(irQ.pop_front()); irQ.push_back(d); end
      S_UPIR: mInstr = {irQ[3], irQ[2], irQ[1], irQ[0]};
      S_CAPDR: begin
        drQ.delete();
        if (mInstr == 4'b0011) begin
          for (int i = 0; i < 32; i++) drQ.push_back(IDFULL[i]);
        end else if (mIsBsr()) begin
          for (int i = 0; i < NI; i++) drQ.push_back(pinIn[i]);
          for (int i = 0; i < NO; i++) drQ.push_back(coreOut[i]);
        end else drQ.push_back(1'b0);
      end
      S_SHDR: begin void'(drQ.pop_front()); drQ.push_back(d); end
      S_UPDR: if (mIsBsr()) for (int i = 0; i < NO; i++) mLatch[i] = drQ[NI + i];
      default: ;
    endcase
    mst = nextSt(mst, t);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit en;
    en = (mst == S_SHDR) || (mst == S_SHIR);
    chk("R9 tdoEn", tdoEn, en);
    if (en) chk("R9 tdo", tdo, (mst == S_SHIR) ? irQ[0] : drQ[0]);
    chk("R7 scanMode", scanMode, mIsExt());
    chk("R7 pinOut", pinOut, mIsExt() ? mLatch : coreOut);
  endtask

  task automatic tick(bit t, bit d);
    tms = t; tdi = d;
    @(posedge tck);
    modelEdge(t, d);
    @(negedge tck); #1;
    compareAll();
  endtask

  task automatic scanIr(input bit [3:0] code, output bit [3:0] got);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin got[i] = tdo; tick(i == 3, code[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scanDr(input int len, input bit [63:0] din, output bit [63:0] got);
    got = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < len; i++) begin got[i] = tdo; tick(i == len - 1, din[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #400000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    bit [3:0] irGot;
    bit [63:0] drGot;
    modelReset();
    coreOut = 4'h5; pinIn = 4'h2;
    #9;
    // R1: reset state
    chk("R1 tdoEn", tdoEn, 1'b0);
    chk("R1 scanMode", scanMode, 1'b0);
    chk("R1 pinOut", pinOut, coreOut);
    @(negedge tck); #1; trstN = 1'b1;
    tick(0, 0);

    // R4: identification after reset
    scanDr(32, 64'h0, drGot);
    chk("R4 idcode", drGot[31:0], IDFULL);

    // R3 and R5: bypass
    scanIr(4'b1111, irGot);
    chk("R3 ir capture", irGot, 4'b0001);
    scanDr(8, 64'hB2, drGot);
    chk("R5 bypass", drGot[7:0], 8'h64);
    scanIr(4'b0101, irGot);
    chk("R3 ir capture", irGot, 4'b0001);
    scanDr(8, 64'hA5, drGot);
    chk("R5 unused code", drGot[7:0], 8'h4A);

    // R9: output holds across the rising edge
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R9 captured bypass", tdo, 1'b0);
    tms = 0; tdi = 1;
    @(posedge tck); modelEdge(0, 1); #1;
    chk("R9 no rising change", tdo, 1'b0);
    @(negedge tck); #1; compareAll();
    chk("R9 falling change", tdo, 1'b1);
    tick(1, 0); tick(1, 0); tick(0, 0);

    // R6: sample
    pinIn = 4'h9; coreOut = 4'h6;
    scanIr(4'b0001, irGot);
    scanDr(8, 64'h3C, drGot);
    chk("R6 sample capture", drGot[7:0], 8'h69);
    chk("R6 scanMode", scanMode, 1'b0);
    chk("R6 pinOut", pinOut, 4'h6);

    // R7: external test
    scanIr(4'b0000, irGot);
    chk("R7 scanMode", scanMode, 1'b1);
    chk("R7 preload drives", pinOut, 4'h3);
    coreOut = 4'hC; tick(0, 0);
    chk("R7 core ignored", pinOut, 4'h3);
    scanDr(8, 64'hA0, drGot);
    chk("R7 extest capture", drGot[7:0], 8'hC9);
    chk("R7 update", pinOut, 4'hA);

    // R8: clamp
    scanIr(4'b0010, irGot);
    chk("R8 scanMode", scanMode, 1'b1);
    chk("R8 pinOut held", pinOut, 4'hA);
    scanDr(6, 64'h2D, drGot);
    chk("R8 one-bit path", drGot[5:0], 6'h1A);
    chk("R8 latch unchanged", pinOut, 4'hA);

    // R2 and R10: five high edges from Shift-DR
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk("R2 tdoEn off", tdoEn, 1'b0);
    tick(0, 0);
    chk("R10 scanMode", scanMode, 1'b0);
    chk("R10 pinOut", pinOut, coreOut);
    scanDr(32, 64'h0, drGot);
    chk("R10 idcode", drGot[31:0], IDFULL);

    // R2 from Pause-IR
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 1); tick(1, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    scanDr(32, 64'h0, drGot);
    chk("R2 idcode after pause", drGot[31:0], IDFULL);

    // R1: asynchronous reset while shifting under EXTEST
    scanIr(4'b0000, irGot);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R9 shift enable", tdoEn, 1'b1);
    #0.5 trstN = 1'b0;
    #0.3;
    chk("R1 async tdoEn", tdoEn, 1'b0);
    chk("R1 async scanMode", scanMode, 1'b0);
    chk("R1 async pinOut", pinOut, coreOut);
    modelReset();
    @(posedge tck); @(negedge tck); #1;
    trstN = 1'b1;
    tick(0, 0);
    scanDr(32, 64'h0, drGot);
    chk("R1 idcode after trst", drGot[31:0], IDFULL);

    finishRun();
  end
endmodule